// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner

This block lights an eight-digit, time-multiplexed seven-segment display from a packed set of BCD digits. The digits are lit one after another, starting with the most significant. Each digit slot ends with a short dark gap. In that gap every digit enable is off, so segment data from one digit cannot leak faintly onto the next.

The slot length comes from the system clock. It is four times 2^PRE_SHIFT clocks in fast-oscillator mode and three times 2^PRE_SHIFT clocks in slow-oscillator mode. The dark gap is the last BLANK_CYC clocks of every slot. Zeros on the left of the number are suppressed until the first nonzero digit or the decimal-point digit, whichever is reached first. That suppression is turned off while the overflow input is high. A single parameter inverts both output buses, for common-anode or common-cathode wiring.

Top module: `dispScan`

## Requirements
- R1: Outside the dark gap exactly one digit enable is active. Enable bit i drives digit i, and digit 0 is the least significant. The digits are scanned in the order 7, 6, …, 0 and then back to 7.
- R2: A digit slot lasts 4·2^PRE_SHIFT clocks when `slowMode` is 0 and 3·2^PRE_SHIFT clocks when `slowMode` is 1.
- R3: During the final BLANK_CYC clocks of each slot, all digit enables and all segment bits are inactive.
- R4: Segment bits 0 to 6 drive segments a to g. BCD values 0 to 9 give the hex patterns 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F. Values 10 to 15 light no segment.
- R5: While `overflow` is 0, digit i with i greater than `dpPos` lights no segment when digits i through 7 are all zero. Its digit enable still follows the scan.
- R6: The digit at `dpPos` and every digit to its right are always decoded, even when they are zero.
- R7: While `overflow` is 1, no digit is suppressed, and leading zeros show the pattern for 0.
- R8: Segment bit 7 (the decimal point) is active only while the digit at `dpPos` is lit.
- R9: With ACTIVE_LOW set to 1, both output buses are the bitwise inverse of their values with ACTIVE_LOW set to 0.
- R10: While `rst` is high, the scan sits at the start of the slot for digit 7, so the enable for digit 7 is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous reset, active high |
| digitsIn | input | 32 | packed BCD digits; nibble i is digit i |
| dpPos | input | 3 | index of the digit that carries the decimal point |
| overflow | input | 1 | disables leading-zero suppression |
| slowMode | input | 1 | 1 selects the 3·2^PRE_SHIFT slot length |
| digitEn | output | 8 | digit enables, one per digit |
| segOut | output | 8 | segments a–g in bits 0–6, decimal point in bit 7 |

## Verification
The bench builds the scanner with PRE_SHIFT=3 and BLANK_CYC=4. Fast slots are then 32 clocks long (28 lit) and slow slots 24 clocks long (20 lit), so the bench can compare every clock of complete eight-digit frames in both modes against its own model. A second instance with ACTIVE_LOW=1 runs alongside the first, which lets the bench check the inversion on every cycle of the same frames.

// File: rtl/dispScanPkg.sv
package dispScanPkg;
  localparam int NUM_DIGITS = 8;
  localparam int IDX_W = $clog2(NUM_DIGITS);
  localparam int SEG_W = 8;

  typedef struct packed {
    logic             litOn;
    logic [IDX_W-1:0] digitIdx;
  } scanStrobe_t;
endpackage

// File: rtl/dispScanCtrl.sv
module dispScanCtrl
  import dispScanPkg::*;
#(
  parameter int PRE_SHIFT = 10,
  parameter int BLANK_CYC = 96
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        slowMode,
  output scanStrobe_t strobe
);
  localparam int CNT_W = PRE_SHIFT + 3;
  localparam logic [CNT_W-1:0] FAST_LEN = CNT_W'(4 << PRE_SHIFT);
  localparam logic [CNT_W-1:0] SLOW_LEN = CNT_W'(3 << PRE_SHIFT);
  localparam logic [CNT_W-1:0] GAP_LEN  = CNT_W'(BLANK_CYC);
  localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(NUM_DIGITS - 1);

  logic [CNT_W-1:0] slotCnt;
  logic [IDX_W-1:0] digitIdx;
  logic [CNT_W-1:0] slotLen;
  logic             slotEnd;

  assign slotLen = slowMode ? SLOW_LEN : FAST_LEN;
  assign slotEnd = slotCnt >= (slotLen - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      slotCnt  <= '0;
      digitIdx <= TOP_IDX;
    end else if (slotEnd) begin
      slotCnt  <= '0;
      digitIdx <= (digitIdx == '0) ? TOP_IDX : digitIdx - IDX_W'(1);
    end else begin
      slotCnt <= slotCnt + CNT_W'(1);
    end
  end

  assign strobe.litOn    = slotCnt < (slotLen - GAP_LEN);
  assign strobe.digitIdx = digitIdx;
endmodule

// File: rtl/dispScanData.sv
module dispScanData
  import dispScanPkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic [NUM_DIGITS*4-1:0] digitsIn,
  input  logic [IDX_W-1:0]        dpPos,
  input  logic                    overflow,
  input  scanStrobe_t             strobe,
  output logic [NUM_DIGITS-1:0]   digitEn,
  output logic [SEG_W-1:0]        segOut
);
  logic [3:0]            nib       [NUM_DIGITS];
  logic [NUM_DIGITS-1:0] leadZero;
  logic [NUM_DIGITS-1:0] suppress;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : gDigit
    assign nib[g] = digitsIn[g*4 +: 4];
    if (g == NUM_DIGITS - 1) begin : gTop
      assign leadZero[g] = (nib[g] == 4'd0);
    end else begin : gRest
      assign leadZero[g] = (nib[g] == 4'd0) && leadZero[g+1];
    end
    assign suppress[g] = !overflow && leadZero[g] && (IDX_W'(g) > dpPos);
  end

  logic [3:0] curNib;
  logic [6:0] curPat;
  logic       dpHere;
  logic [NUM_DIGITS-1:0] enRaw;
  logic [SEG_W-1:0]      segRaw;

  assign curNib = nib[strobe.digitIdx];
  assign dpHere = strobe.digitIdx == dpPos;

  always_comb begin
    unique case (curNib)
      4'd0:    curPat = 7'h3F;
      4'd1:    curPat = 7'h06;
      4'd2:    curPat = 7'h5B;
      4'd3:    curPat = 7'h4F;
      4'd4:    curPat = 7'h66;
      4'd5:    curPat = 7'h6D;
      4'd6:    curPat = 7'h7D;
      4'd7:    curPat = 7'h07;
      4'd8:    curPat = 7'h7F;
      4'd9:    curPat = 7'h6F;
      default: curPat = 7'h00;
    endcase
  end

  always_comb begin
    enRaw  = '0;
    segRaw = '0;
    if (strobe.litOn) begin
      enRaw  = NUM_DIGITS'(1) << strobe.digitIdx;
      segRaw = {dpHere, suppress[strobe.digitIdx] ? 7'h00 : curPat};
    end
  end

  if (ACTIVE_LOW) begin : gInv
    assign digitEn = ~enRaw;
    assign segOut  = ~segRaw;
  end else begin : gPass
    assign digitEn = enRaw;
    assign segOut  = segRaw;
  end
endmodule

// File: rtl/dispScan.sv
module dispScan
  import dispScanPkg::*;
#(
  parameter int PRE_SHIFT  = 10,
  parameter int BLANK_CYC  = 96,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] digitsIn,
  input  logic [2:0]  dpPos,
  input  logic        overflow,
  input  logic        slowMode,
  output logic [7:0]  digitEn,
  output logic [7:0]  segOut
);
  scanStrobe_t strobe;

  dispScanCtrl #(.PRE_SHIFT(PRE_SHIFT), .BLANK_CYC(BLANK_CYC)) ctrl (
    .clk(clk), .rst(rst), .slowMode(slowMode), .strobe(strobe)
  );

  dispScanData #(.ACTIVE_LOW(ACTIVE_LOW)) data (
    .digitsIn(digitsIn), .dpPos(dpPos), .overflow(overflow),
    .strobe(strobe), .digitEn(digitEn), .segOut(segOut)
  );
endmodule

// File: rtl/dispScanChk.sv
module dispScanChk #(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] dpPos,
  input logic [7:0] digitEn,
  input logic [7:0] segOut
);
  logic [7:0] enN;
  logic [7:0] segN;
  logic [7:0] lastOn;

  assign enN  = ACTIVE_LOW ? ~digitEn : digitEn;
  assign segN = ACTIVE_LOW ? ~segOut  : segOut;

  always_ff @(posedge clk) begin
    if (rst)             lastOn <= '0;
    else if (enN != '0)  lastOn <= enN;
  end

  // R1
  one_digit_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(enN));

  // R1
  scan_order_chk: assert property (@(posedge clk) disable iff (rst)
    (enN != '0 && lastOn != '0 && enN != lastOn) |-> (enN == {lastOn[0], lastOn[7:1]}));

  // R3
  gap_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (enN == '0) |-> (segN == '0));

  // R8
  dp_place_chk: assert property (@(posedge clk) disable iff (rst)
    segN[7] |-> (enN == (8'd1 << dpPos)));
endmodule

bind dispScan dispScanChk #(.ACTIVE_LOW(ACTIVE_LOW)) chk (
  .clk(clk), .rst(rst), .dpPos(dpPos), .digitEn(digitEn), .segOut(segOut)
);

// File: tb/dispScan_test.sv
`timescale 1ns/1ps
module dispScan_test;
  localparam int SHIFT = 3;
  localparam int GAP   = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] digitsIn = '0;
  logic [2:0]  dpPos = '0;
  logic        overflow = 1'b0;
  logic        slowMode = 1'b0;
  logic [7:0]  digitEn, segOut, digitEnInv, segOutInv;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  dispScan #(.PRE_SHIFT(SHIFT), .BLANK_CYC(GAP), .ACTIVE_LOW(1'b0)) uut (
    .clk(clk), .rst(rst), .digitsIn(digitsIn), .dpPos(dpPos),
    .overflow(overflow), .slowMode(slowMode), .digitEn(digitEn), .segOut(segOut)
  );

  dispScan #(.PRE_SHIFT(SHIFT), .BLANK_CYC(GAP), .ACTIVE_LOW(1'b1)) uutInv (
    .clk(clk), .rst(rst), .digitsIn(digitsIn), .dpPos(dpPos),
    .overflow(overflow), .slowMode(slowMode), .digitEn(digitEnInv), .segOut(segOutInv)
  );

  function automatic logic [6:0] pattern(input logic [3:0] v);
    case (v)
      4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
      4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
      4'd6: return 7'h7D;  4'd7: return 7'h07;  4'd8: return 7'h7F;
      4'd9: return 7'h6F;  default: return 7'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic startRun(input logic [31:0] d, input logic [2:0] dp,
                          input logic ovf, input logic slow);
    @(negedge clk);
    rst = 1'b1;
    digitsIn = d; dpPos = dp; overflow = ovf; slowMode = slow;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  // compares every clock of one full frame against the model
  task automatic checkFrame(input string tag);
    int slotLen = slowMode ? (3 << SHIFT) : (4 << SHIFT);
    for (int k = 0; k < 8 * slotLen; k++) begin
      int idx = 7 - (k / slotLen);
      bit lit = (k % slotLen) < (slotLen - GAP);
      bit sup = !overflow && (idx > dpPos);
      logic [7:0] expEn = '0;
      logic [7:0] expSeg = '0;
      for (int j = idx; j < 8; j++)
        if (digitsIn[j*4 +: 4] != 4'd0) sup = 1'b0;
      if (lit) begin
        expEn  = 8'd1 << idx;
        expSeg = {idx == dpPos, sup ? 7'h00 : pattern(digitsIn[idx*4 +: 4])};
      end
      check({tag, " en"}, digitEn, expEn);
      check({tag, " seg"}, segOut, expSeg);
      // R9 inverted instance mirrors the direct one
      check("R9 en", digitEnInv, ~expEn);
      check("R9 seg", segOutInv, ~expSeg);
      @(negedge clk);
      #1;
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R10 reset en", digitEn, 8'h80);
    check("R9 reset en", digitEnInv, 8'h7F);
  endtask

  task automatic testScanFast();   // R1 R2 R3 R4 R6 R8
    startRun(32'h9876_5432, 3'd0, 1'b0, 1'b0);
    checkFrame("R1/R2/R3/R4 fast");
  endtask

  task automatic testScanSlow();   // R2 slow slot
    startRun(32'h1234_5678, 3'd2, 1'b0, 1'b1);
    checkFrame("R2 slow");
  endtask

  task automatic testLeadZero();   // R5
    startRun(32'h0000_0305, 3'd0, 1'b0, 1'b0);
    checkFrame("R5 lead zero");
  endtask

  task automatic testDpStop();     // R6 R8
    startRun(32'h0000_0000, 3'd3, 1'b0, 1'b1);
    checkFrame("R6/R8 dp stop");
  endtask

  task automatic testOverflow();   // R7
    startRun(32'h0000_0000, 3'd0, 1'b1, 1'b0);
    checkFrame("R7 overflow");
  endtask

  task automatic testHighCodes();  // R4 codes 10..15
    startRun(32'hABCD_EF98, 3'd5, 1'b0, 1'b0);
    checkFrame("R4 high codes");
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      finishRun();
    end
  end

  initial begin
    testReset();
    testScanFast();
    testScanSlow();
    testLeadZero();
    testDpStop();
    testOverflow();
    testHighCodes();
    finishRun();
  end
endmodule